// File: doc/BRIEF.md
# 32-bit SEC-DED Memory Error Detection and Correction Unit

This unit protects 32-bit memory words with seven check bits from an odd-column-weight Hamming code. On a write it produces the check bits for the word held in its data latch. On a read it compares freshly regenerated check bits against the stored ones to form a syndrome. It reports single and multiple errors on two active-low flags. In the correcting modes it inverts a single failing data bit on its way into the output latch. That latch feeds four byte lanes, and each lane has its own enable. The bidirectional memory data lines are modelled as separate input, output and per-lane enable ports.

A diagnostic register loads from the data lines. Its low byte can stand in for the stored check bits, and a 3-bit field in its second byte can take over mode selection. All latches are modelled as clock-edge registers that load on every rising edge while their enable is high.

The mode controller is a registered state machine with the states ST_GEN, ST_DETECT, ST_CORRECT, ST_PASS, ST_DDETECT and ST_DCORRECT. On every edge it moves to the state named by the selected mode code. The mode code comes from `mode_sel`, or from the diagnostic field when `mode_sel` is 7. The codes 6 and 7 found in the diagnostic field lead to ST_DETECT. From any state, a low `out_le` leads to ST_GEN (forced generate). Reset enters ST_GEN.

Top module: `edc32_secded`

## Requirements
- R1: `data_in` is captured into the data latch on each rising edge with `data_le` high, and `chk_in` into the check latch with `chk_le` high. Both latches hold while their enables are low. Reset clears every latch to zero.
- R2: With the unit in generate mode (mode code 0), `chk_out` equals the generated check bits and both flags are high. Check bit j is the XOR of the data bits i for which bit j of column i is set. Column i is the i-th smallest (from zero) 7-bit value with exactly three ones.
- R3: In mode codes 1 (detect) and 2 (correct), `chk_out` shows the syndrome, which is the generated check bits XOR the stored check bits. A zero syndrome leaves `err_n` and `merr_n` high.
- R4: A syndrome equal to one data column or to a single check-bit position drives `err_n` low and keeps `merr_n` high. A check-bit error is flagged, but `chk_out` still shows the raw syndrome.
- R5: In correct mode, a single data-bit error is inverted before the word enters the output latch. In detect mode, the latch receives the word uncorrected.
- R6: A nonzero even-weight syndrome, or an odd-weight syndrome that matches no column and no check position, drives both flags low and changes no data bit.
- R7: In pass-through (code 3), the output latch loads the data latch unchanged, `chk_out` shows the stored check latch, and both flags are high.
- R8: Lane k drives `data_out[8k+7:8k]` from the output latch and raises `data_oe[k]` only while `lane_oe[k]` is high. A disabled lane reads zero.
- R9: The output latch loads on a rising edge only while `out_le` is high, and it holds otherwise.
- R10: A low `out_le` puts the unit in generate mode from the next edge, whatever the selected mode. The flags then go high and `chk_out` shows the generated check bits.
- R11: The diagnostic register loads on `diag_le` from `data_in[6:0]` (check bits) and `data_in[10:8]` (mode field). Codes 4 and 5 act as detect and correct, with the stored check bits taken from the diagnostic check field.
- R12: With `mode_sel` equal to 7, the diagnostic mode field chooses the operating mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 32 | Incoming data lines |
| data_le | input | 1 | Data latch load enable |
| chk_in | input | 7 | Check bits read from memory |
| chk_le | input | 1 | Check latch load enable |
| diag_le | input | 1 | Diagnostic register load enable |
| out_le | input | 1 | Output latch enable; low forces generate mode |
| mode_sel | input | 3 | External mode code |
| lane_oe | input | 4 | Per-byte output enables |
| data_out | output | 32 | Output latch value, gated per lane |
| data_oe | output | 4 | Per-lane drive enables |
| chk_out | output | 7 | Generated check bits, syndrome or stored check bits |
| err_n | output | 1 | Low on any detected error |
| merr_n | output | 1 | Low on a multiple error |

## Verification
The assertions assume that reset is held for at least one edge and that `out_le`, `mode_sel` and the latch enables change only between edges. They also assume that at most one data bit is flipped by any syndrome, which depends on the matrix having distinct columns. The stimulus holds every input pattern for two full edges before sampling. This lets the mode state settle before the output latch captures the corrected word. The stimulus changes inputs only at falling edges, and it raises `out_le` for every read so that the forced-generate path is entered only on purpose.

// File: rtl/edc32_pkg.sv
package edc32_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int LANE_W = 8;
    localparam int COL_WEIGHT = 3;

    typedef enum logic [2:0] {
        MD_GEN      = 3'd0,
        MD_DETECT   = 3'd1,
        MD_CORRECT  = 3'd2,
        MD_PASS     = 3'd3,
        MD_DDETECT  = 3'd4,
        MD_DCORRECT = 3'd5,
        MD_RSVD     = 3'd6,
        MD_INTERNAL = 3'd7
    } mode_code_t;

    typedef enum logic [2:0] {
        ST_GEN,
        ST_DETECT,
        ST_CORRECT,
        ST_PASS,
        ST_DDETECT,
        ST_DCORRECT
    } op_state_t;

    typedef enum logic [1:0] {
        SEL_GEN,
        SEL_SYN,
        SEL_RAW
    } chk_sel_t;

    // Column idx of the parity-check matrix: the idx-th smallest
    // CHK_W-bit value of weight COL_WEIGHT.
    function automatic logic [CHK_W-1:0] hcol(input int idx);
        logic [CHK_W-1:0] res;
        int n;
        res = '0;
        n = 0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            if ($countones(v[CHK_W-1:0]) == COL_WEIGHT) begin
                if (n == idx) res = v[CHK_W-1:0];
                n++;
            end
        end
        return res;
    endfunction

    // Row j of the matrix as a mask over the data bits.
    function automatic logic [DATA_W-1:0] row_mask(input int j);
        logic [DATA_W-1:0] m;
        logic [CHK_W-1:0] c;
        for (int i = 0; i < DATA_W; i++) begin
            c = hcol(i);
            m[i] = c[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/edc32_chkgen.sv
module edc32_chkgen #(
    parameter int DW = edc32_pkg::DATA_W,
    parameter int CW = edc32_pkg::CHK_W
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] chk
);
    for (genvar j = 0; j < CW; j++) begin : g_row
        localparam logic [DW-1:0] MASK = edc32_pkg::row_mask(j);
        assign chk[j] = ^(data & MASK);
    end
endmodule

// File: rtl/edc32_syndec.sv
module edc32_syndec #(
    parameter int DW = edc32_pkg::DATA_W,
    parameter int CW = edc32_pkg::CHK_W
) (
    input  logic [CW-1:0] syn,
    output logic [DW-1:0] flip,
    output logic          single_err,
    output logic          multi_err
);
    logic data_hit;
    logic chk_hit;

    for (genvar i = 0; i < DW; i++) begin : g_col
        localparam logic [CW-1:0] COL = edc32_pkg::hcol(i);
        assign flip[i] = (syn == COL);
    end

    assign data_hit   = |flip;
    assign chk_hit    = $onehot(syn);
    assign single_err = data_hit | chk_hit;
    assign multi_err  = (|syn) & ~data_hit & ~chk_hit;
endmodule

// File: rtl/edc32_mode_fsm.sv
module edc32_mode_fsm
    import edc32_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  mode_sel,
    input  logic [2:0]  diag_mode,
    input  logic        out_le,
    output op_state_t   state,
    output chk_sel_t    chk_sel,
    output logic        flag_en,
    output logic        fix_en,
    output logic        diag_src
);
    op_state_t  state_nx;
    mode_code_t src_code;
    logic       past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_GEN;
            past_ok <= 1'b0;
        end else begin
            state   <= state_nx;
            past_ok <= 1'b1;
        end
    end

    always_comb begin
        src_code = mode_code_t'(mode_sel);
        if (src_code == MD_INTERNAL) src_code = mode_code_t'(diag_mode);
        state_nx = ST_DETECT;
        if (!out_le) begin
            state_nx = ST_GEN;
        end else begin
            unique case (src_code)
                MD_GEN:      state_nx = ST_GEN;
                MD_DETECT:   state_nx = ST_DETECT;
                MD_CORRECT:  state_nx = ST_CORRECT;
                MD_PASS:     state_nx = ST_PASS;
                MD_DDETECT:  state_nx = ST_DDETECT;
                MD_DCORRECT: state_nx = ST_DCORRECT;
                MD_RSVD:     state_nx = ST_DETECT;
                MD_INTERNAL: state_nx = ST_DETECT;
                default:     state_nx = ST_DETECT;
            endcase
        end
    end

    always_comb begin
        chk_sel  = SEL_GEN;
        flag_en  = 1'b0;
        fix_en   = 1'b0;
        diag_src = 1'b0;
        unique case (state)
            ST_GEN: begin
                chk_sel = SEL_GEN;
            end
            ST_DETECT: begin
                chk_sel = SEL_SYN;
                flag_en = 1'b1;
            end
            ST_CORRECT: begin
                chk_sel = SEL_SYN;
                flag_en = 1'b1;
                fix_en  = 1'b1;
            end
            ST_PASS: begin
                chk_sel = SEL_RAW;
            end
            ST_DDETECT: begin
                chk_sel  = SEL_SYN;
                flag_en  = 1'b1;
                diag_src = 1'b1;
            end
            ST_DCORRECT: begin
                chk_sel  = SEL_SYN;
                flag_en  = 1'b1;
                fix_en   = 1'b1;
                diag_src = 1'b1;
            end
            default: begin
                chk_sel = SEL_GEN;
            end
        endcase
    end

    // R10: a low output enable forces generate on the next edge
    assert_gen_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(out_le)) |-> (state == ST_GEN));

    // R7: pass-through code selected externally reaches ST_PASS
    assert_pass_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(out_le) && $past(mode_sel) == 3'd3) |-> (state == ST_PASS));
endmodule

// File: rtl/edc32_secded.sv
module edc32_secded
    import edc32_pkg::*;
#(
    parameter int DW       = DATA_W,
    parameter int CW       = CHK_W,
    parameter int LW       = LANE_W,
    parameter int MODE_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    data_in,
    input  logic             data_le,
    input  logic [CW-1:0]    chk_in,
    input  logic             chk_le,
    input  logic             diag_le,
    input  logic             out_le,
    input  logic [2:0]       mode_sel,
    input  logic [DW/LW-1:0] lane_oe,
    output logic [DW-1:0]    data_out,
    output logic [DW/LW-1:0] data_oe,
    output logic [CW-1:0]    chk_out,
    output logic             err_n,
    output logic             merr_n
);
    localparam int NLANE = DW / LW;

    logic [DW-1:0] data_q;
    logic [CW-1:0] chk_q;
    logic [CW-1:0] diag_chk_q;
    logic [2:0]    diag_mode_q;
    logic [DW-1:0] out_q;
    logic          past_ok;

    logic [CW-1:0] gen_chk;
    logic [CW-1:0] chk_src;
    logic [CW-1:0] syn;
    logic [DW-1:0] flip;
    logic          single_err;
    logic          multi_err;
    logic [DW-1:0] out_next;

    op_state_t state;
    chk_sel_t  chk_sel;
    logic      flag_en;
    logic      fix_en;
    logic      diag_src;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q      <= '0;
            chk_q       <= '0;
            diag_chk_q  <= '0;
            diag_mode_q <= '0;
            out_q       <= '0;
            past_ok     <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (data_le) data_q <= data_in;
            if (chk_le)  chk_q  <= chk_in;
            if (diag_le) begin
                diag_chk_q  <= data_in[CW-1:0];
                diag_mode_q <= data_in[MODE_LSB +: 3];
            end
            if (out_le) out_q <= out_next;
        end
    end

    edc32_chkgen #(.DW(DW), .CW(CW)) u_chkgen (
        .data (data_q),
        .chk  (gen_chk)
    );

    assign chk_src = diag_src ? diag_chk_q : chk_q;
    assign syn     = gen_chk ^ chk_src;

    edc32_syndec #(.DW(DW), .CW(CW)) u_syndec (
        .syn        (syn),
        .flip       (flip),
        .single_err (single_err),
        .multi_err  (multi_err)
    );

    edc32_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .diag_mode (diag_mode_q),
        .out_le    (out_le),
        .state     (state),
        .chk_sel   (chk_sel),
        .flag_en   (flag_en),
        .fix_en    (fix_en),
        .diag_src  (diag_src)
    );

    assign out_next = fix_en ? (data_q ^ flip) : data_q;
    assign err_n    = ~(flag_en & (single_err | multi_err));
    assign merr_n   = ~(flag_en & multi_err);

    always_comb begin
        unique case (chk_sel)
            SEL_GEN: chk_out = gen_chk;
            SEL_SYN: chk_out = syn;
            SEL_RAW: chk_out = chk_q;
            default: chk_out = gen_chk;
        endcase
    end

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        assign data_out[k*LW +: LW] = lane_oe[k] ? out_q[k*LW +: LW] : '0;
        assign data_oe[k]           = lane_oe[k];
    end

    // R1: data latch holds while its enable is low
    assert_in_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(data_le)) |-> $stable(data_q));

    // R9: output latch holds while its enable is low
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(out_le)) |-> $stable(out_q));

    // R5: correction changes at most one bit
    assert_fix_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_next ^ data_q) <= 1);

    // R6: a multiple error leaves the data untouched
    assert_nofix_multi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        multi_err |-> (out_next == data_q));

    // R6: multiple-error flag never appears without the error flag
    assert_flag_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !merr_n |-> !err_n);
endmodule

// File: tb/edc32_secded_tb.sv
module edc32_secded_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] data_in;
    logic        data_le, chk_le, diag_le, out_le;
    logic [6:0]  chk_in;
    logic [2:0]  mode_sel;
    logic [3:0]  lane_oe;
    logic [31:0] data_out;
    logic [3:0]  data_oe;
    logic [6:0]  chk_out;
    logic        err_n, merr_n;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  oe;
        logic        e;
        logic        m;
        logic [6:0]  c;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    event  ev_sample;

    always #(CLK_PERIOD/2) clk = ~clk;

    edc32_secded u_dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .data_le(data_le),
        .chk_in(chk_in), .chk_le(chk_le), .diag_le(diag_le), .out_le(out_le),
        .mode_sel(mode_sel), .lane_oe(lane_oe), .data_out(data_out),
        .data_oe(data_oe), .chk_out(chk_out), .err_n(err_n), .merr_n(merr_n)
    );

    // Matrix column per R2: i-th smallest 7-bit value with three ones
    function automatic logic [6:0] bcol(input int i);
        logic [6:0] r;
        int n;
        r = '0;
        n = 0;
        for (int v = 0; v < 128; v++) begin
            if ($countones(v[6:0]) == 3) begin
                if (n == i) r = v[6:0];
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [6:0] ref_chk(input logic [31:0] d);
        logic [6:0] c;
        c = '0;
        for (int i = 0; i < 32; i++) if (d[i]) c ^= bcol(i);
        return c;
    endfunction

    // position p: 0..31 data bit, 32..38 check bit
    function automatic logic [6:0] pos_syn(input int p);
        return (p < 32) ? bcol(p) : 7'(1 << (p - 32));
    endfunction

    task automatic compare(input string r, input string f,
                           input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", r, f, act, expv);
        end
    endtask

    // monitor: pops expected items when the driver signals a sample point
    initial begin
        forever begin
            @(ev_sample);
            while (exp_q.size() > 0) begin
                exp_t  it;
                string r;
                it = exp_q.pop_front();
                r  = req_q.pop_front();
                compare(r, "data_out", data_out, it.d);
                compare(r, "data_oe", 32'(data_oe), 32'(it.oe));
                compare(r, "err_n", 32'(err_n), 32'(it.e));
                compare(r, "merr_n", 32'(merr_n), 32'(it.m));
                compare(r, "chk_out", 32'(chk_out), 32'(it.c));
            end
        end
    end

    // driver: apply a pattern for two edges, then sample at the falling edge
    task automatic step(input logic [31:0] din, input logic dle,
                        input logic [6:0] cin, input logic cle,
                        input logic dgle, input logic ole,
                        input logic [2:0] md, input logic [3:0] oe,
                        input logic [31:0] e_d, input logic e_e, input logic e_m,
                        input logic [6:0] e_c, input string r);
        exp_t it;
        data_in = din; data_le = dle; chk_in = cin; chk_le = cle;
        diag_le = dgle; out_le = ole; mode_sel = md; lane_oe = oe;
        it.d = e_d; it.oe = oe; it.e = e_e; it.m = e_m; it.c = e_c;
        exp_q.push_back(it);
        req_q.push_back(r);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        ->ev_sample;
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] d, d2, d3, d4;
        exp_t it;
        rst_n = 1'b0;
        data_in = '0; data_le = 0; chk_in = '0; chk_le = 0;
        diag_le = 0; out_le = 0; mode_sel = 3'd0; lane_oe = 4'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        it.d = '0; it.oe = 4'h0; it.e = 1; it.m = 1; it.c = '0;
        exp_q.push_back(it); req_q.push_back("R1 reset");
        ->ev_sample;
        #1;
        rst_n = 1'b1;

        for (int t = 0; t < 6; t++) begin
            d = $urandom() ^ (32'h1 << t);
            // R2: generate mode
            step(d, 1, 7'h00, 1, 0, 1, 3'd0, 4'hF, d, 1, 1, ref_chk(d), "R2");
            // R3: clean word in correct mode
            step(d, 1, ref_chk(d), 1, 0, 1, 3'd2, 4'hF, d, 1, 1, 7'h00, "R3");
        end

        d = 32'hC3A5_17E9;
        for (int i = 0; i < 32; i++) begin
            // R4 R5: single data error corrected
            step(d ^ (32'h1 << i), 1, ref_chk(d), 1, 0, 1, 3'd2, 4'hF,
                 d, 0, 1, bcol(i), "R4 R5 correct");
        end
        for (int i = 0; i < 32; i += 5) begin
            // R5: detect mode keeps the raw word
            step(d ^ (32'h1 << i), 1, ref_chk(d), 1, 0, 1, 3'd1, 4'hF,
                 d ^ (32'h1 << i), 0, 1, bcol(i), "R5 detect");
        end
        for (int j = 0; j < 7; j++) begin
            // R4: check-bit error flagged, syndrome shown uncorrected
            step(d, 1, ref_chk(d) ^ 7'(1 << j), 1, 0, 1, 3'd2, 4'hF,
                 d, 0, 1, 7'(1 << j), "R4 check bit");
        end
        for (int a = 0; a < 39; a++) begin
            int b;
            logic [31:0] dd;
            logic [6:0]  cc;
            b  = (a + 7) % 39;
            dd = d;
            cc = ref_chk(d);
            if (a < 32) dd[a] = ~dd[a]; else cc[a-32] = ~cc[a-32];
            if (b < 32) dd[b] = ~dd[b]; else cc[b-32] = ~cc[b-32];
            // R6: double error, no change
            step(dd, 1, cc, 1, 0, 1, 3'd2, 4'hF, dd, 0, 0,
                 pos_syn(a) ^ pos_syn(b), "R6 double");
        end
        for (int u = 32; u < 35; u++) begin
            // R6: unmatched weight-3 syndrome
            step(d ^ 32'h10, 1, ref_chk(d ^ 32'h10) ^ bcol(u), 1, 0, 1, 3'd2, 4'hF,
                 d ^ 32'h10, 0, 0, bcol(u), "R6 unmatched");
        end

        // R7: pass-through ignores errors
        step(d ^ 32'h8, 1, 7'h2A, 1, 0, 1, 3'd3, 4'hF, d ^ 32'h8, 1, 1, 7'h2A, "R7");

        // R8: lane enables
        step(d, 1, ref_chk(d), 1, 0, 1, 3'd2, 4'b0101, d & 32'h00FF_00FF, 1, 1, 7'h00, "R8");
        step(d, 1, ref_chk(d), 1, 0, 1, 3'd2, 4'b1010, d & 32'hFF00_FF00, 1, 1, 7'h00, "R8");
        step(d, 1, ref_chk(d), 1, 0, 1, 3'd2, 4'hF, d, 1, 1, 7'h00, "R8");

        // R9 R10: low out_le holds the output and forces generate mode
        d2 = 32'h5A5A_0F0F;
        step(d2, 1, ref_chk(d2) ^ 7'h01, 1, 0, 0, 3'd1, 4'hF, d, 1, 1, ref_chk(d2), "R9 R10");

        // R1: latches hold with enables low (pass shows stored values)
        step(32'hFFFF_FFFF, 0, 7'h7F, 0, 0, 1, 3'd3, 4'hF, d2, 1, 1, ref_chk(d2) ^ 7'h01, "R1");

        // R11: diagnostic check bits in diagnostic correct mode
        d3 = 32'h1234_5678;
        step({21'h0, 3'd0, 1'b0, ref_chk(d3)}, 0, 7'h00, 0, 1, 0, 3'd0, 4'hF,
             d2, 1, 1, ref_chk(d2), "R11 load");
        step(d3 ^ 32'h20, 1, 7'h55, 1, 0, 1, 3'd5, 4'hF, d3, 0, 1, bcol(5), "R11 correct");
        step(d3 ^ 32'h20, 1, 7'h55, 1, 0, 1, 3'd4, 4'hF, d3 ^ 32'h20, 0, 1, bcol(5), "R11 detect");

        // R12: internal control takes the mode from the diagnostic field
        d4 = 32'h89AB_CDEF;
        step({21'h0, 3'd2, 1'b0, 7'h00}, 0, 7'h00, 0, 1, 0, 3'd0, 4'hF,
             d3 ^ 32'h20, 1, 1, ref_chk(d3 ^ 32'h20), "R12 load");
        step(d4 ^ 32'h200, 1, ref_chk(d4), 1, 0, 1, 3'd7, 4'hF, d4, 0, 1, bcol(9), "R12 correct");
        step({21'h0, 3'd3, 1'b0, 7'h00}, 0, 7'h00, 0, 1, 0, 3'd0, 4'hF,
             d4, 1, 1, ref_chk(d4 ^ 32'h200), "R12 load");
        step(d4 ^ 32'h200, 1, 7'h11, 1, 0, 1, 3'd7, 4'hF, d4 ^ 32'h200, 1, 1, 7'h11, "R12 pass");

        summary();
    end
endmodule